// File: doc/BRIEF.md
# Legacy Display Window Forwarding Decoder

This block sits in the request path of a bus bridge and decides, one request at a time, whether a memory or I/O transaction should cross the bridge. It recognises the fixed legacy display address windows. One is a memory window. The other is a set of I/O port ranges that repeat every 1 KB within the lowest 64 KB of I/O space. When the display window enable is set and a request hits one of these windows, the block overrides whatever the bridge's ordinary window logic concluded. The override lets the request cross from the primary side to the secondary side and stops it from crossing the other way.

With the enable clear, or for an address outside the legacy windows, the decision is taken from the ordinary window-decode input without change. The enable is a one-bit configuration register. It is written through a simple write strobe, read back on a port, cleared by power-on reset and also cleared by a warm reset pulse. The decision is registered: a request presented at one clock edge produces its result on the outputs after that edge.

Top module: `vga_fwd_decoder`

## Requirements
- R1: While `rst_n` is low and after its release, `dec_valid`, `dec_forward`, `dec_block`, `dec_vga` and `cfg_en` are 0 until a request or a write is presented.
- R2: A clock edge with `cfg_we`=1 and `warm_rst`=0 loads `cfg_wdata` into the enable, and the new value is visible on `cfg_en` after that edge.
- R3: A clock edge with `warm_rst`=1 clears the enable to 0, even if `cfg_we`=1 with `cfg_wdata`=1 in the same cycle.
- R4: In memory space (`req_is_io`=0), an address matches the display window exactly when it lies in 0xA0000 to 0xBFFFF inclusive; 0x9FFFF and 0xC0000 do not match.
- R5: A memory address with any bit set above bit 19 never matches the display window.
- R6: In I/O space (`req_is_io`=1), an address matches only when its low 10 bits fall in 0x3B0 to 0x3BB or in 0x3C0 to 0x3DF; for example 0x3AF, 0x3BC and 0x3E0 do not match.
- R7: For an I/O match, address bits 15:10 may take any value (1 KB aliases match), while any set bit at position 16 or above prevents a match.
- R8: With the enable set and a window match on a primary-to-secondary request (`req_dir`=0), the result is `dec_forward`=1, `dec_block`=0, `dec_vga`=1, whatever `win_fwd` says.
- R9: With the enable set and a window match on a secondary-to-primary request (`req_dir`=1), the result is `dec_forward`=0, `dec_block`=1, `dec_vga`=1, whatever `win_fwd` says; `dec_forward` and `dec_block` are never 1 together.
- R10: With the enable clear, or with no window match, the result is `dec_forward`=`win_fwd`, `dec_block`=0, `dec_vga`=0.
- R11: The outputs for a request sampled at a clock edge appear after that same edge and hold for one cycle; `dec_valid` follows `req_valid` by one cycle, and a cycle without `req_valid` gives 0 on `dec_valid`, `dec_forward`, `dec_block` and `dec_vga`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| warm_rst | input | 1 | Synchronous warm reset pulse; clears the enable |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_wdata | input | 1 | Value written to the enable register |
| cfg_en | output | 1 | Current enable register value |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | ADDR_W (32) | Request address |
| req_is_io | input | 1 | Address space: 0 memory, 1 I/O |
| req_dir | input | 1 | Direction: 0 primary-to-secondary, 1 secondary-to-primary |
| win_fwd | input | 1 | Forward result from the ordinary window decode |
| dec_valid | output | 1 | Registered decision is valid |
| dec_forward | output | 1 | Request is forwarded across the bridge |
| dec_block | output | 1 | Forwarding is suppressed by the display window override |
| dec_vga | output | 1 | The display window override decided this request |

## Verification
The properties take for granted that `win_fwd`, `req_dir` and `req_is_io` carry their meaning only in cycles with `req_valid` set, and that the enable is not written and used for a decision in the same cycle. The bench keeps to this by writing the enable in cycles of its own, before any request that depends on it, and by driving each request for a single cycle, then waiting for the result. All stimulus changes on the falling edge, so the registered result is read a full half period after the rising edge that captured it.

// File: rtl/vga_fwd_pkg.sv
`timescale 1ns/1ps
package vga_fwd_pkg;

  typedef enum logic {
    SPACE_MEM = 1'b0,
    SPACE_IO  = 1'b1
  } space_e;

  typedef enum logic {
    DIR_DOWN = 1'b0,  // primary to secondary
    DIR_UP   = 1'b1   // secondary to primary
  } dir_e;

  typedef struct packed {
    logic fwd;
    logic blk;
    logic vga;
  } decision_t;

endpackage

// File: rtl/vga_mem_match.sv
`timescale 1ns/1ps
module vga_mem_match #(
  parameter int ADDR_W = 32,
  parameter int WIN_W  = 20,
  parameter logic [WIN_W-1:0] WIN_LO = 20'hA0000,
  parameter logic [WIN_W-1:0] WIN_HI = 20'hBFFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  localparam int HI_W = ADDR_W - WIN_W;

  logic             upper_zero;
  logic [WIN_W-1:0] low_part;

  generate
    if (HI_W > 0) begin : g_upper
      assign upper_zero = (addr[ADDR_W-1:WIN_W] == '0);
    end else begin : g_no_upper
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign low_part = addr[WIN_W-1:0];

  always_comb begin
    hit = upper_zero && (low_part >= WIN_LO) && (low_part <= WIN_HI);
  end

endmodule

// File: rtl/vga_io_match.sv
`timescale 1ns/1ps
module vga_io_match #(
  parameter int ADDR_W  = 32,
  parameter int SPACE_W = 16,
  parameter int ALIAS_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  localparam int NRANGE = 2;
  localparam logic [ALIAS_W-1:0] RANGE_LO [NRANGE] = '{10'h3B0, 10'h3C0};
  localparam logic [ALIAS_W-1:0] RANGE_HI [NRANGE] = '{10'h3BB, 10'h3DF};

  logic               in_space;
  logic [ALIAS_W-1:0] port_bits;
  logic [NRANGE-1:0]  range_hit;

  generate
    if (ADDR_W > SPACE_W) begin : g_upper
      assign in_space = (addr[ADDR_W-1:SPACE_W] == '0);
    end else begin : g_no_upper
      assign in_space = 1'b1;
    end
  endgenerate

  // bits SPACE_W-1 down to ALIAS_W are deliberately left out of the compare
  assign port_bits = addr[ALIAS_W-1:0];

  genvar gi;
  generate
    for (gi = 0; gi < NRANGE; gi++) begin : g_range
      assign range_hit[gi] = (port_bits >= RANGE_LO[gi]) && (port_bits <= RANGE_HI[gi]);
    end
  endgenerate

  always_comb begin
    hit = in_space && (|range_hit);
  end

endmodule

// File: rtl/vga_en_reg.sv
`timescale 1ns/1ps
module vga_en_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic warm_rst,
  input  logic we,
  input  logic wdata,
  output logic en_q
);

  logic en_d;
  logic en_ce;

  always_comb begin
    en_ce = warm_rst | we;
    en_d  = warm_rst ? 1'b0 : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

endmodule

// File: rtl/vga_fwd_decoder.sv
`timescale 1ns/1ps
module vga_fwd_decoder
  import vga_fwd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              cfg_we,
  input  logic              cfg_wdata,
  output logic              cfg_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_io,
  input  logic              req_dir,
  input  logic              win_fwd,
  output logic              dec_valid,
  output logic              dec_forward,
  output logic              dec_block,
  output logic              dec_vga
);

  space_e    space;
  dir_e      dir;
  logic      mem_hit;
  logic      io_hit;
  logic      win_hit;
  decision_t dec_d;
  decision_t dec_q;
  logic      valid_q;

  assign space = space_e'(req_is_io);
  assign dir   = dir_e'(req_dir);

  vga_en_reg u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .warm_rst (warm_rst),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .en_q     (cfg_en)
  );

  vga_mem_match #(.ADDR_W(ADDR_W)) u_mem (
    .addr (req_addr),
    .hit  (mem_hit)
  );

  vga_io_match #(.ADDR_W(ADDR_W)) u_io (
    .addr (req_addr),
    .hit  (io_hit)
  );

  // next-state decision
  always_comb begin
    win_hit = (space == SPACE_IO) ? io_hit : mem_hit;
    dec_d   = '0;
    if (req_valid) begin
      if (cfg_en && win_hit) begin
        dec_d.vga = 1'b1;
        dec_d.fwd = (dir == DIR_DOWN);
        dec_d.blk = (dir == DIR_UP);
      end else begin
        dec_d.fwd = win_fwd;
      end
    end
  end

  // decision register, always loaded
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      dec_q   <= dec_d;
      valid_q <= req_valid;
    end
  end

  assign dec_valid   = valid_q;
  assign dec_forward = dec_q.fwd;
  assign dec_block   = dec_q.blk;
  assign dec_vga     = dec_q.vga;

endmodule

// File: rtl/vga_fwd_decoder_chk.sv
`timescale 1ns/1ps
module vga_fwd_decoder_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              warm_rst,
  input logic              cfg_we,
  input logic              cfg_wdata,
  input logic              cfg_en,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_is_io,
  input logic              req_dir,
  input logic              win_fwd,
  input logic              dec_valid,
  input logic              dec_forward,
  input logic              dec_block,
  input logic              dec_vga
);

  p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !warm_rst) |=> (cfg_en == $past(cfg_wdata)));

  p_warm_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> !cfg_en);

  p_down_never_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_dir) |=> !dec_block);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_forward && dec_block));

  p_block_is_vga_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_block |-> dec_vga);

  p_disabled_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cfg_en) |=> (dec_forward == $past(win_fwd)) && !dec_block && !dec_vga);

  p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> dec_valid);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!dec_valid && !dec_forward && !dec_block && !dec_vga));

endmodule

bind vga_fwd_decoder vga_fwd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .warm_rst    (warm_rst),
  .cfg_we      (cfg_we),
  .cfg_wdata   (cfg_wdata),
  .cfg_en      (cfg_en),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .req_is_io   (req_is_io),
  .req_dir     (req_dir),
  .win_fwd     (win_fwd),
  .dec_valid   (dec_valid),
  .dec_forward (dec_forward),
  .dec_block   (dec_block),
  .dec_vga     (dec_vga)
);

// File: tb/vga_fwd_decoder_tb.sv
`timescale 1ns/1ps
module vga_fwd_decoder_tb;

  localparam int ADDR_W = 32;
  localparam int NV     = 20;
  // {tag[3:0], en, is_io, dir, win, addr[31:0], exp_fwd, exp_blk, exp_vga}
  localparam logic [42:0] VEC [NV] = '{
    {4'd4,  1'b1, 1'b0, 1'b0, 1'b0, 32'h000A0000, 1'b1, 1'b0, 1'b1}, // R4 low edge
    {4'd4,  1'b1, 1'b0, 1'b0, 1'b0, 32'h000BFFFF, 1'b1, 1'b0, 1'b1}, // R4 high edge
    {4'd4,  1'b1, 1'b0, 1'b0, 1'b1, 32'h0009FFFF, 1'b1, 1'b0, 1'b0}, // R4 below
    {4'd4,  1'b1, 1'b0, 1'b0, 1'b0, 32'h000C0000, 1'b0, 1'b0, 1'b0}, // R4 above
    {4'd5,  1'b1, 1'b0, 1'b0, 1'b1, 32'h100A0000, 1'b1, 1'b0, 1'b0}, // R5 upper bit
    {4'd6,  1'b1, 1'b1, 1'b0, 1'b0, 32'h000003B0, 1'b1, 1'b0, 1'b1}, // R6
    {4'd6,  1'b1, 1'b1, 1'b0, 1'b0, 32'h000003BB, 1'b1, 1'b0, 1'b1}, // R6
    {4'd6,  1'b1, 1'b1, 1'b0, 1'b0, 32'h000003BC, 1'b0, 1'b0, 1'b0}, // R6 gap
    {4'd6,  1'b1, 1'b1, 1'b0, 1'b0, 32'h000003DF, 1'b1, 1'b0, 1'b1}, // R6
    {4'd6,  1'b1, 1'b1, 1'b0, 1'b0, 32'h000003E0, 1'b0, 1'b0, 1'b0}, // R6 above
    {4'd6,  1'b1, 1'b1, 1'b0, 1'b1, 32'h000003AF, 1'b1, 1'b0, 1'b0}, // R6 below
    {4'd7,  1'b1, 1'b1, 1'b0, 1'b0, 32'h0000FFC0, 1'b1, 1'b0, 1'b1}, // R7 alias
    {4'd7,  1'b1, 1'b1, 1'b0, 1'b0, 32'h000107C0, 1'b0, 1'b0, 1'b0}, // R7 bit 16
    {4'd9,  1'b1, 1'b0, 1'b1, 1'b1, 32'h000B0000, 1'b0, 1'b1, 1'b1}, // R9 mem up
    {4'd9,  1'b1, 1'b1, 1'b1, 1'b1, 32'h000003D0, 1'b0, 1'b1, 1'b1}, // R9 io up
    {4'd8,  1'b1, 1'b1, 1'b0, 1'b0, 32'h0000C3B5, 1'b1, 1'b0, 1'b1}, // R8 override
    {4'd10, 1'b0, 1'b0, 1'b0, 1'b0, 32'h000A0000, 1'b0, 1'b0, 1'b0}, // R10
    {4'd10, 1'b0, 1'b0, 1'b1, 1'b1, 32'h000A0000, 1'b1, 1'b0, 1'b0}, // R10
    {4'd10, 1'b0, 1'b1, 1'b1, 1'b0, 32'h000003C0, 1'b0, 1'b0, 1'b0}, // R10
    {4'd4,  1'b1, 1'b0, 1'b0, 1'b0, 32'h000003C0, 1'b0, 1'b0, 1'b0}  // R4 mem space
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              warm_rst = 1'b0;
  logic              cfg_we = 1'b0;
  logic              cfg_wdata = 1'b0;
  logic              cfg_en;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_is_io = 1'b0;
  logic              req_dir = 1'b0;
  logic              win_fwd = 1'b0;
  logic              dec_valid;
  logic              dec_forward;
  logic              dec_block;
  logic              dec_vga;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  vga_fwd_decoder #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_en(cfg_en), .req_valid(req_valid),
    .req_addr(req_addr), .req_is_io(req_is_io), .req_dir(req_dir),
    .win_fwd(win_fwd), .dec_valid(dec_valid), .dec_forward(dec_forward),
    .dec_block(dec_block), .dec_vga(dec_vga)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {valid,fwd,blk,vga} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_en(input string req, input logic exp);
    n_checks++;
    if (cfg_en !== exp) begin
      n_fail++;
      $display("FAIL %s: cfg_en actual %b expected %b", req, cfg_en, exp);
    end
  endtask

  task automatic write_en(input logic v, input logic warm);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v; warm_rst = warm;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = 1'b0; warm_rst = 1'b0;
  endtask

  task automatic drive_req(input logic [ADDR_W-1:0] a, input logic io,
                           input logic d, input logic w);
    req_valid = 1'b1; req_addr = a; req_is_io = io; req_dir = d; win_fwd = w;
  endtask

  task automatic idle_req();
    req_valid = 1'b0; req_addr = '0; req_is_io = 1'b0; req_dir = 1'b0; win_fwd = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #12;
    check("R1 in reset", {dec_valid, dec_forward, dec_block, dec_vga}, 4'b0000);
    check_en("R1 in reset", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {dec_valid, dec_forward, dec_block, dec_vga}, 4'b0000);
    check_en("R1 after release", 1'b0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[42:39], i);
      if (cfg_en !== v[38]) write_en(v[38], 1'b0);
      @(negedge clk);
      drive_req(v[34:3], v[37], v[36], v[35]);
      @(negedge clk);
      idle_req();
      check(tag, {dec_valid, dec_forward, dec_block, dec_vga}, {1'b1, v[2:0]});
    end

    // R2: write and readback
    write_en(1'b0, 1'b0);
    check_en("R2 write 0", 1'b0);
    write_en(1'b1, 1'b0);
    check_en("R2 write 1", 1'b1);

    // R3: warm reset clears, wins over a write of 1
    write_en(1'b1, 1'b1);
    check_en("R3 warm with write", 1'b0);
    write_en(1'b1, 1'b0);
    @(negedge clk);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    check_en("R3 warm alone", 1'b0);

    // R11: idle cycle with a matching address gives nothing
    write_en(1'b1, 1'b0);
    @(negedge clk);
    drive_req(32'h000A0000, 1'b0, 1'b0, 1'b1);
    req_valid = 1'b0;
    @(negedge clk);
    check("R11 no valid", {dec_valid, dec_forward, dec_block, dec_vga}, 4'b0000);

    // R11: back-to-back requests, each result one cycle later
    drive_req(32'h000A0000, 1'b0, 1'b1, 1'b1);   // up, match -> block
    @(negedge clk);
    drive_req(32'h000003C5, 1'b1, 1'b0, 1'b0);   // down, match -> forward
    check("R11 b2b first (R9)", {dec_valid, dec_forward, dec_block, dec_vga}, 4'b1011);
    @(negedge clk);
    idle_req();
    check("R11 b2b second (R8)", {dec_valid, dec_forward, dec_block, dec_vga}, 4'b1101);
    @(negedge clk);
    check("R11 returns idle", {dec_valid, dec_forward, dec_block, dec_vga}, 4'b0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule